// File: doc/BRIEF.md
# Single-Precision Predicate Comparator

This block compares two single-precision floating-point operands under one of seven predicates and returns a one-bit answer together with an invalid-operation indication. Some predicates are ordered: they are false whenever a NaN is present. Others are unordered: they are true for a NaN pair. Independently of that, each predicate is either quiet or signaling, and this decides when the invalid flag is raised.

The operands and the 3-bit predicate code are presented on every cycle. The answer and the flag appear on registered outputs at the first rising clock edge after the inputs, so a new comparison can be issued every cycle. A synchronous, active-high reset clears both outputs. The exponent and fraction widths are parameters. Their defaults give the 32-bit single format.

Top module: `fcmp_unit`

## Requirements
- R1: `cmp_true` and `cmp_invalid` reflect the inputs sampled at the previous rising edge (one cycle of latency, one comparison per cycle), and a cycle with `rst` high leaves both outputs at 0.
- R2: Code 0 (unordered test) yields true exactly when at least one operand is a NaN. A NaN has all exponent bits set and a nonzero fraction.
- R3: Code 1 (ordered equal) yields true only when neither operand is a NaN and the two values are equal.
- R4: Code 2 (unordered-or-equal) yields true when the values are equal or at least one operand is a NaN.
- R5: Code 3 (signaling less-than) yields true only for an ordered pair with a < b.
- R6: Code 4 (unordered-or-less) yields true when a < b or at least one operand is a NaN.
- R7: Code 5 (signaling less-or-equal) yields true only for an ordered pair with a <= b.
- R8: Code 6 (unordered-or-less-or-equal) yields true unless a > b, so a NaN pair gives true.
- R9: +0 and -0 compare equal. Infinities order by sign: -inf is below every finite value, and every finite value is below +inf.
- R10: Codes 3 and 5 raise `cmp_invalid` whenever either operand is any NaN, quiet or signaling.
- R11: Codes 0, 1, 2, 4 and 6 raise `cmp_invalid` only when an operand is a signaling NaN. A signaling NaN is a NaN whose fraction MSB is 0. A quiet NaN has a fraction MSB of 1.
- R12: Code 7 is unused and yields 0 on both outputs for any operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | Left operand (sign, exponent, fraction) |
| op_b | input | 32 | Right operand |
| pred_sel | input | 3 | Predicate code, 0..6 as listed, 7 unused |
| cmp_true | output | 1 | Registered predicate result |
| cmp_invalid | output | 1 | Registered invalid-operation flag |

## Verification
There is only one register stage, so a wrong operand class or a wrong relation shows up at the ports in the cycle after the inputs are applied. A signaling/quiet misclassification appears on `cmp_invalid` for the quiet predicates. A wrong ordering of signed magnitudes, zeros or infinities appears on `cmp_true` for the less-than and equality codes. Each scenario uses operand pairs where exactly one of these faults would flip an output, and it samples that output one cycle later.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Predicate codes; the numeric values are the interface contract.
  typedef enum logic [2:0] {
    PRED_UNORD  = 3'd0,
    PRED_EQ_ORD = 3'd1,
    PRED_EQ_ANY = 3'd2,
    PRED_LT_SIG = 3'd3,
    PRED_LT_ANY = 3'd4,
    PRED_LE_SIG = 3'd5,
    PRED_LE_ANY = 3'd6,
    PRED_RSVD   = 3'd7
  } pred_e;

  // Outcome of comparing a against b: exactly one bit is set.
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic un;
  } rel_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op,
  output logic         is_nan,
  output logic         is_snan,
  output logic         is_zero,
  output logic         sign,
  output logic [W-2:0] mag
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f   = op[W-2:FRAC_W];
  assign frac_f  = op[FRAC_W-1:0];
  assign is_nan  = (&exp_f) & (|frac_f);
  // Quiet bit is the fraction MSB; clear means signaling.
  assign is_snan = is_nan & ~frac_f[FRAC_W-1];
  assign is_zero = ~|op[W-2:0];
  assign sign    = op[W-1];
  assign mag     = op[W-2:0];
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  logic             a_nan,
  input  logic             b_nan,
  input  logic             a_zero,
  input  logic             b_zero,
  input  logic             a_sign,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic [MAG_W-1:0] b_mag,
  output rel_t             rel
);
  logic mag_lt;
  logic mag_eq;

  assign mag_lt = a_mag < b_mag;
  assign mag_eq = a_mag == b_mag;

  always_comb begin
    rel = '0;
    if (a_nan || b_nan) begin
      rel.un = 1'b1;
    end else if (a_zero && b_zero) begin
      rel.eq = 1'b1;                 // signed zeros are equal
    end else if (a_sign != b_sign) begin
      rel.lt = a_sign;
      rel.gt = b_sign;
    end else if (mag_eq) begin
      rel.eq = 1'b1;
    end else if (!a_sign) begin
      rel.lt = mag_lt;
      rel.gt = ~mag_lt;
    end else begin
      rel.lt = ~mag_lt;              // negative: larger magnitude is smaller
      rel.gt = mag_lt;
    end
  end
endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate
  import fcmp_pkg::*;
(
  input  pred_e sel,
  input  rel_t  rel,
  input  logic  any_snan,
  output logic  res,
  output logic  inv
);
  always_comb begin
    res = 1'b0;
    inv = 1'b0;
    unique case (sel)
      PRED_UNORD:  begin res = rel.un;             inv = any_snan; end
      PRED_EQ_ORD: begin res = rel.eq;             inv = any_snan; end
      PRED_EQ_ANY: begin res = rel.eq | rel.un;    inv = any_snan; end
      PRED_LT_SIG: begin res = rel.lt;             inv = rel.un;   end
      PRED_LT_ANY: begin res = rel.lt | rel.un;    inv = any_snan; end
      PRED_LE_SIG: begin res = rel.lt | rel.eq;    inv = rel.un;   end
      PRED_LE_ANY: begin res = ~rel.gt;            inv = any_snan; end
      default:     begin res = 1'b0;               inv = 1'b0;     end
    endcase
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   pred_sel,
  output logic         cmp_true,
  output logic         cmp_invalid
);
  logic [W-1:0] ops [2];
  logic [1:0]   nan_v, snan_v, zero_v, sign_v;
  logic [W-2:0] mag_v [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op      (ops[i]),
      .is_nan  (nan_v[i]),
      .is_snan (snan_v[i]),
      .is_zero (zero_v[i]),
      .sign    (sign_v[i]),
      .mag     (mag_v[i])
    );
  end

  rel_t rel;
  fcmp_relate #(.MAG_W(W-1)) u_rel (
    .a_nan  (nan_v[0]),  .b_nan  (nan_v[1]),
    .a_zero (zero_v[0]), .b_zero (zero_v[1]),
    .a_sign (sign_v[0]), .b_sign (sign_v[1]),
    .a_mag  (mag_v[0]),  .b_mag  (mag_v[1]),
    .rel    (rel)
  );

  logic res_d, inv_d;
  fcmp_predicate u_pred (
    .sel      (pred_e'(pred_sel)),
    .rel      (rel),
    .any_snan (|snan_v),
    .res      (res_d),
    .inv      (inv_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_true    <= 1'b0;
      cmp_invalid <= 1'b0;
    end else begin
      cmp_true    <= res_d;
      cmp_invalid <= inv_d;
    end
  end

  // Set once a non-reset edge has loaded the output register.
  logic primed_q;
  always_ff @(posedge clk) begin
    if (rst) primed_q <= 1'b0;
    else     primed_q <= 1'b1;
  end

  assert_rel_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot({rel.lt, rel.eq, rel.gt, rel.un}));

  assert_unord_nan_R2: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(pred_sel) == 3'd0) |-> (cmp_true == $past(|nan_v)));

  assert_sig_nan_R10: assert property (@(posedge clk) disable iff (rst)
    (primed_q && ($past(pred_sel) == 3'd3 || $past(pred_sel) == 3'd5) && $past(|nan_v))
      |-> (!cmp_true && cmp_invalid));

  assert_quiet_no_inv_R11: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(pred_sel) != 3'd3 && $past(pred_sel) != 3'd5 && !$past(|snan_v))
      |-> !cmp_invalid);

  assert_reserved_R12: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(pred_sel) == 3'd7) |-> (!cmp_true && !cmp_invalid));

  assert_ule_not_gt_R8: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(pred_sel) == 3'd6) |-> (cmp_true == !$past(rel.gt)));
endmodule

// File: tb/sim_fcmp_unit.sv
module sim_fcmp_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [2:0]  pred_sel = '0;
  logic        cmp_true, cmp_invalid;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;

  localparam logic [31:0] P0 = 32'h0000_0000, N0 = 32'h8000_0000;
  localparam logic [31:0] P1 = 32'h3F80_0000, N1 = 32'hBF80_0000;
  localparam logic [31:0] P2 = 32'h4000_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] PMAX = 32'h7F7F_FFFF, NMAX = 32'hFF7F_FFFF;
  localparam logic [31:0] QNAN = 32'h7FC0_0000, SNAN = 32'h7F80_0001;

  always #2 clk = ~clk;   // 4 ns period

  fcmp_unit u0 (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .pred_sel(pred_sel),
    .cmp_true(cmp_true), .cmp_invalid(cmp_invalid)
  );

  task automatic check(string tag, logic exp_r, logic exp_i);
    n_chk++;
    if (cmp_true !== exp_r || cmp_invalid !== exp_i) begin
      n_bad++;
      $display("FAIL %s: got res=%b inv=%b, expected res=%b inv=%b",
               tag, cmp_true, cmp_invalid, exp_r, exp_i);
    end
  endtask

  // Drive at falling edge, result registered at next rising edge.
  task automatic apply(string tag, logic [31:0] a, logic [31:0] b, logic [2:0] p,
                       logic exp_r, logic exp_i);
    @(negedge clk);
    op_a = a; op_b = b; pred_sel = p;
    @(posedge clk);
    #1;
    check(tag, exp_r, exp_i);
  endtask

  task automatic t_reset();
    @(negedge clk);
    op_a = SNAN; op_b = P1; pred_sel = 3'd3;
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset clears", 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_unord();
    apply("R2 ordered pair", P1, P2, 3'd0, 1'b0, 1'b0);
    apply("R2 quiet nan",    QNAN, P1, 3'd0, 1'b1, 1'b0);
    apply("R11 un snan",     P1, SNAN, 3'd0, 1'b1, 1'b1);
  endtask

  task automatic t_equal();
    apply("R3 equal",        P1, P1, 3'd1, 1'b1, 1'b0);
    apply("R3 differ",       P1, P2, 3'd1, 1'b0, 1'b0);
    apply("R3 nan pair",     QNAN, QNAN, 3'd1, 1'b0, 1'b0);
    apply("R4 nan",          QNAN, P1, 3'd2, 1'b1, 1'b0);
    apply("R4 differ",       P1, P2, 3'd2, 1'b0, 1'b0);
    apply("R11 ueq snan",    SNAN, P1, 3'd2, 1'b1, 1'b1);
  endtask

  task automatic t_less();
    apply("R5 less",         P1, P2, 3'd3, 1'b1, 1'b0);
    apply("R5 greater",      P2, P1, 3'd3, 1'b0, 1'b0);
    apply("R5 equal",        P1, P1, 3'd3, 1'b0, 1'b0);
    apply("R10 olt qnan",    QNAN, P1, 3'd3, 1'b0, 1'b1);
    apply("R6 nan",          QNAN, P1, 3'd4, 1'b1, 1'b0);
    apply("R6 negatives",    N2, N1, 3'd4, 1'b1, 1'b0);
    apply("R6 neg reverse",  N1, N2, 3'd4, 1'b0, 1'b0);
  endtask

  task automatic t_lesseq();
    apply("R7 equal",        P1, P1, 3'd5, 1'b1, 1'b0);
    apply("R7 greater",      P2, P1, 3'd5, 1'b0, 1'b0);
    apply("R10 ole qnan",    P1, QNAN, 3'd5, 1'b0, 1'b1);
    apply("R8 greater",      P2, P1, 3'd6, 1'b0, 1'b0);
    apply("R8 nan",          P1, QNAN, 3'd6, 1'b1, 1'b0);
    apply("R11 ule snan",    SNAN, P1, 3'd6, 1'b1, 1'b1);
  endtask

  task automatic t_zero_inf();
    apply("R9 zeros oeq",    P0, N0, 3'd1, 1'b1, 1'b0);
    apply("R9 zeros olt",    N0, P0, 3'd3, 1'b0, 1'b0);
    apply("R9 zeros ole",    N0, P0, 3'd5, 1'b1, 1'b0);
    apply("R9 -inf < +inf",  NINF, PINF, 3'd3, 1'b1, 1'b0);
    apply("R9 max < +inf",   PMAX, PINF, 3'd3, 1'b1, 1'b0);
    apply("R9 inf equal",    PINF, PINF, 3'd1, 1'b1, 1'b0);
    apply("R9 -inf < -max",  NINF, NMAX, 3'd3, 1'b1, 1'b0);
    apply("R9 neg < pos",    N1, P0, 3'd3, 1'b1, 1'b0);
  endtask

  task automatic t_reserved();
    apply("R12 snan",        SNAN, P1, 3'd7, 1'b0, 1'b0);
    apply("R12 ordered",     P1, P2, 3'd7, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    // Predicate flips each cycle on the same operands: R1 throughput.
    for (int k = 0; k < 4; k++) begin
      apply("R1 pipelined lt", P1, P2, 3'd3, 1'b1, 1'b0);
      apply("R1 pipelined eq", P1, P2, 3'd1, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_unord();
    t_equal();
    t_less();
    t_lesseq();
    t_zero_inf();
    t_reserved();
    t_back_to_back();
    t_reset();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule